// File: doc/BRIEF.md
# Data-Valid and Field Status Generator

This block drives two status pins seen by an external microcontroller: an active-low data-ready flag that tells the controller a freshly acquired data line is waiting to be read, and an active-high first-field flag that follows the interlaced field sequence. It sits between the acquisition buffer, the video timing logic and the serial slave interface, and it sees all of them only as single-cycle strobes. The acquisition buffer pulses a commit when a valid line has been stored. The timing logic pulses at each field start, with a level that says which field is starting, and at the start of line 16. The serial slave pulses when the master declines to acknowledge a byte to end a read.

The clear rule for the data-ready flag depends on the operating mode. In the dedicated-line mode the flag is withdrawn at the start of line 16. In the packet and header modes it is withdrawn at the next field start, which is where the next data entry window opens. A master not-acknowledge withdraws it in every mode. A commit in the same cycle as any clear keeps the flag asserted. A test pin overrides both outputs so that they copy a chip-select pin. Meanwhile the internal state keeps tracking events, and the outputs show that state again once the test pin drops.

Top module: `dv_field_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `data_ready_n` to 1 and `first_field` to 0 after that edge, whatever the other inputs, the test pin included.
- R2: With `test_pin` low, a `commit` pulse drives `data_ready_n` to 0 after the same clock edge, in either mode.
- R3: With `mode_vps` = 1, a `line16_start` pulse without `commit` returns `data_ready_n` to 1 after the edge; a `field_start` pulse leaves it unchanged.
- R4: With `mode_vps` = 0, a `field_start` pulse without `commit` returns `data_ready_n` to 1 after the edge; a `line16_start` pulse leaves it unchanged.
- R5: A `master_nack` pulse without `commit` returns `data_ready_n` to 1 after the edge, in either mode.
- R6: When `commit` and a clear event (mode-selected strobe or `master_nack`) fall in the same cycle, `data_ready_n` is 0 after the edge.
- R7: A `field_start` pulse sets `first_field` to the level of `field_is_first` (1 = the first field is starting, 0 = the second) after the edge; `first_field` changes at no other time apart from reset.
- R8: While `test_pin` is high, both outputs equal, after each edge, the level `chip_sel` had before it. Events during that time still update the internal state, and after `test_pin` falls the outputs show that state from the next edge on.
- R9: With `test_pin` low in the current and the previous cycle and no event in the current cycle, both outputs keep their values across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_vps | input | 1 | 1 = dedicated-line mode, 0 = packet or header mode |
| commit | input | 1 | Single-cycle pulse: valid line stored by the acquisition buffer |
| field_start | input | 1 | Single-cycle pulse at the start of each field |
| field_is_first | input | 1 | Qualifies `field_start`: 1 = first field starts, 0 = second field starts |
| line16_start | input | 1 | Single-cycle pulse at the start of line 16 |
| master_nack | input | 1 | Single-cycle pulse: master did not acknowledge a read byte |
| test_pin | input | 1 | Test override, active high |
| chip_sel | input | 1 | Chip-select pin level, copied to the outputs in test mode |
| data_ready_n | output | 1 | Registered data-ready flag, active low |
| first_field | output | 1 | Registered first-field flag, active high |

## Verification
The main stimulus is a walked vector sequence that puts each clear strobe in both modes, so the mode-selected clear is told apart from the strobe the mode must ignore. It also pairs commit with each clear source in one cycle, which separates set-over-clear priority from a plain clear. Field starts with both qualifier levels show whether the first-field flag follows the qualifier or just toggles. The test-mode rows carry events under the override and then release it, which shows whether the override hides the state tracking or stops it. Directed cases add reset with the flag set and with the test pin high, and a long idle stretch for the hold rule.

// File: rtl/dvf_pkg.sv
package dvf_pkg;

  // Strobes and qualifiers seen in one clock cycle
  typedef struct packed {
    logic commit;
    logic field_start;
    logic field_is_first;
    logic line16_start;
    logic master_nack;
  } dvf_evt_t;

  // Clear condition: mode-selected timing strobe or master not-acknowledge
  function automatic logic f_clear(input dvf_evt_t e, input logic vps);
    logic timing_clr;
    timing_clr = vps ? e.line16_start : e.field_start;
    return timing_clr | e.master_nack;
  endfunction

  // Valid flag update: a set outranks a clear in the same cycle
  function automatic logic f_valid_next(input logic cur, input logic set_i,
                                        input logic clr_i);
    logic nxt;
    if (set_i)      nxt = 1'b1;
    else if (clr_i) nxt = 1'b0;
    else            nxt = cur;
    return nxt;
  endfunction

  // Field flag update: load the qualifier at each field start
  function automatic logic f_field_next(input logic cur, input logic fs,
                                        input logic first);
    return fs ? first : cur;
  endfunction

endpackage

// File: rtl/dvf_valid_track.sv
module dvf_valid_track
  import dvf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_vps,
  input  dvf_evt_t evt,
  output logic     set_evt,
  output logic     clr_evt,
  output logic     valid_d,
  output logic     valid_q
);

  assign set_evt = evt.commit;
  assign clr_evt = f_clear(evt, mode_vps);
  assign valid_d = f_valid_next(valid_q, set_evt, clr_evt);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= valid_d;
  end

endmodule

// File: rtl/dvf_field_track.sv
module dvf_field_track
  import dvf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dvf_evt_t evt,
  output logic     field_d,
  output logic     field_q
);

  assign field_d = f_field_next(field_q, evt.field_start, evt.field_is_first);

  always_ff @(posedge clk) begin
    if (rst) field_q <= 1'b0;
    else     field_q <= field_d;
  end

endmodule

// File: rtl/dvf_out_stage.sv
module dvf_out_stage #(
  parameter int          NUM_OUT = 2,
  parameter logic [NUM_OUT-1:0] RST_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               test_pin,
  input  logic               chip_sel,
  input  logic [NUM_OUT-1:0] pin_d,
  output logic [NUM_OUT-1:0] pin_q
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)           pin_q[i] <= RST_VAL[i];
      else if (test_pin) pin_q[i] <= chip_sel;
      else               pin_q[i] <= pin_d[i];
    end
  end

endmodule

// File: rtl/dv_field_status.sv
module dv_field_status
  import dvf_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_vps,
  input  logic commit,
  input  logic field_start,
  input  logic field_is_first,
  input  logic line16_start,
  input  logic master_nack,
  input  logic test_pin,
  input  logic chip_sel,
  output logic data_ready_n,
  output logic first_field
);

  localparam int IDX_READY = 0;
  localparam int IDX_FIELD = 1;
  localparam logic [NUM_OUT-1:0] OUT_RST = NUM_OUT'(1) << IDX_READY;

  dvf_evt_t evt;
  logic set_evt, clr_evt;
  logic valid_d, valid_q;
  logic field_d, field_q;
  logic [NUM_OUT-1:0] pin_d, pin_q;

  assign evt = '{commit:         commit,
                 field_start:    field_start,
                 field_is_first: field_is_first,
                 line16_start:   line16_start,
                 master_nack:    master_nack};

  dvf_valid_track u_valid (
    .clk(clk), .rst(rst), .mode_vps(mode_vps), .evt(evt),
    .set_evt(set_evt), .clr_evt(clr_evt),
    .valid_d(valid_d), .valid_q(valid_q)
  );

  dvf_field_track u_field (
    .clk(clk), .rst(rst), .evt(evt),
    .field_d(field_d), .field_q(field_q)
  );

  always_comb begin
    pin_d            = '0;
    pin_d[IDX_READY] = ~valid_d;
    pin_d[IDX_FIELD] = field_d;
  end

  dvf_out_stage #(.NUM_OUT(NUM_OUT), .RST_VAL(OUT_RST)) u_out (
    .clk(clk), .rst(rst), .test_pin(test_pin), .chip_sel(chip_sel),
    .pin_d(pin_d), .pin_q(pin_q)
  );

  assign data_ready_n = pin_q[IDX_READY];
  assign first_field  = pin_q[IDX_FIELD];

endmodule

// File: rtl/dvf_checker.sv
module dvf_checker (
  input logic clk,
  input logic rst,
  input logic mode_vps,
  input logic commit,
  input logic field_start,
  input logic field_is_first,
  input logic line16_start,
  input logic master_nack,
  input logic test_pin,
  input logic chip_sel,
  input logic set_evt,
  input logic clr_evt,
  input logic data_ready_n,
  input logic first_field
);

  AST_RESET_VALUES: assert property (@(posedge clk) rst |=> (data_ready_n && !first_field)); // R1
  AST_COMMIT_SETS: assert property (@(posedge clk) disable iff (rst) (!test_pin && commit) |=> !data_ready_n); // R2
  AST_VPS_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst) (!test_pin && mode_vps && line16_start && !commit) |=> data_ready_n); // R3
  AST_PKT_FIELD_CLEAR: assert property (@(posedge clk) disable iff (rst) (!test_pin && !mode_vps && field_start && !commit) |=> data_ready_n); // R4
  AST_NACK_CLEAR: assert property (@(posedge clk) disable iff (rst) (!test_pin && master_nack && !commit) |=> data_ready_n); // R5
  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst) (!test_pin && set_evt && clr_evt) |=> !data_ready_n); // R6
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (rst) (!test_pin && field_start) |=> (first_field == $past(field_is_first))); // R7
  AST_TEST_MIRROR: assert property (@(posedge clk) disable iff (rst) test_pin |=> (data_ready_n == $past(chip_sel) && first_field == $past(chip_sel))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!test_pin && !$past(test_pin) && !commit && !field_start && !line16_start && !master_nack) |=> ($stable(data_ready_n) && $stable(first_field))); // R9

endmodule

bind dv_field_status dvf_checker u_chk (
  .clk(clk), .rst(rst), .mode_vps(mode_vps), .commit(commit),
  .field_start(field_start), .field_is_first(field_is_first),
  .line16_start(line16_start), .master_nack(master_nack),
  .test_pin(test_pin), .chip_sel(chip_sel),
  .set_evt(set_evt), .clr_evt(clr_evt),
  .data_ready_n(data_ready_n), .first_field(first_field)
);

// File: tb/sim_dv_field_status.sv
`timescale 1ns/1ps
module sim_dv_field_status;

  logic clk = 1'b0;
  logic rst, mode_vps, commit, field_start, field_is_first;
  logic line16_start, master_nack, test_pin, chip_sel;
  logic data_ready_n, first_field;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dv_field_status u0 (
    .clk(clk), .rst(rst), .mode_vps(mode_vps), .commit(commit),
    .field_start(field_start), .field_is_first(field_is_first),
    .line16_start(line16_start), .master_nack(master_nack),
    .test_pin(test_pin), .chip_sel(chip_sel),
    .data_ready_n(data_ready_n), .first_field(first_field)
  );

  // {req[3:0], test, csel, vps, commit, fstart, ffirst, l16, nack, exp_ready_n, exp_first}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {4'd9, 8'b00000000, 2'b10}, // R9 idle, packet mode
    {4'd2, 8'b00010000, 2'b00}, // R2 commit
    {4'd4, 8'b00000010, 2'b00}, // R4 line 16 ignored in packet mode
    {4'd9, 8'b00000000, 2'b00}, // R9 hold
    {4'd4, 8'b00001100, 2'b11}, // R4 field start clears, R7 first field
    {4'd2, 8'b00010000, 2'b01}, // R2 commit again
    {4'd6, 8'b00011000, 2'b00}, // R6 commit with field start, R7 second field
    {4'd5, 8'b00000001, 2'b10}, // R5 nack clears
    {4'd2, 8'b00110000, 2'b00}, // R2 commit in VPS mode
    {4'd3, 8'b00101100, 2'b01}, // R3 field start ignored in VPS mode
    {4'd3, 8'b00100010, 2'b11}, // R3 line 16 clears
    {4'd6, 8'b00110010, 2'b01}, // R6 commit with line 16
    {4'd6, 8'b00110001, 2'b01}, // R6 commit with nack
    {4'd5, 8'b00100001, 2'b11}, // R5 nack clears in VPS mode
    {4'd2, 8'b00110000, 2'b01}, // R2 commit
    {4'd8, 8'b11100000, 2'b11}, // R8 mirror chip select high
    {4'd8, 8'b10100000, 2'b00}, // R8 mirror chip select low
    {4'd8, 8'b10100001, 2'b00}, // R8 nack under override
    {4'd8, 8'b11101000, 2'b11}, // R8 second field under override
    {4'd8, 8'b00100000, 2'b10}, // R8 released: shows tracked state
    {4'd2, 8'b00110000, 2'b00}  // R2 commit after release
  };

  task automatic drive(input logic [7:0] s);
    {test_pin, chip_sel, mode_vps, commit, field_start, field_is_first,
     line16_start, master_nack} = s;
  endtask

  task automatic check(input string req, input logic exp_n, input logic exp_f);
    checks++;
    if (data_ready_n !== exp_n || first_field !== exp_f) begin
      errors++;
      $display("FAIL %s ready_n=%b first=%b expected ready_n=%b first=%b",
               req, data_ready_n, first_field, exp_n, exp_f);
    end
  endtask

  // apply one cycle of stimulus at the falling edge, sample after the rising edge
  task automatic step(input logic [7:0] s);
    @(negedge clk);
    drive(s);
    @(posedge clk);
    #5;
  endtask

  initial begin
    rst = 1'b1;
    drive(8'b0);
    repeat (3) @(posedge clk);
    #5;
    check("R1", 1'b1, 1'b0);   // R1 initial reset state
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:2]);
      check($sformatf("R%0d", VEC[i][13:10]), VEC[i][1], VEC[i][0]);
    end

    // R9 long idle hold with flag asserted
    for (int i = 0; i < 20; i++) begin
      step(8'b00100000);
      check("R9", 1'b0, 1'b0);
    end

    // R7 first field set, then reset with flag and field set
    step(8'b00101100);
    check("R7", 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    drive(8'b00010000);
    @(posedge clk);
    #5;
    check("R1", 1'b1, 1'b0);   // R1 reset beats commit

    // R1 reset beats test override with chip select high
    @(negedge clk);
    drive(8'b11000000);
    @(posedge clk);
    #5;
    check("R1", 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    step(8'b00000000);
    check("R1", 1'b1, 1'b0);   // state cleared by reset

    // R4 packet mode field-start clear with second field
    step(8'b00010000);
    check("R2", 1'b0, 1'b0);
    step(8'b00001000);
    check("R4", 1'b1, 1'b0);

    @(negedge clk);
    drive(8'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule